// File: doc/BRIEF.md
# Serial Port Register File with Transmit and Receive Queues

This block is the software-facing half of an asynchronous serial port. A host reaches it over a simple 32-bit register bus with an address, a write strobe, a read strobe, write data and registered read data. Bytes to send go into a transmit queue through a byte-wide buffer register. Received bytes come out of a receive queue through a second buffer register. A serial bit engine sits next to the block. It drains the transmit queue through a pop port and fills the receive queue through a push port, which also carries parity and framing error marks for each byte.

Receive errors collect in sticky flags. Software cannot write these flags, or the receiver enable, directly. It changes them only by writing strobe bits to a separate set/clear register. Each queue has an enable, a self-clearing flush and an interrupt trigger level. A status word reports both fill levels and the free space in the transmit queue. Three interrupt lines (transmit, receive and error) each carry a pending request that stays set until software clears it. The block also stores the line-control word, the pin-select choice, the baud reload value and the clock gate and divider settings, and drives each of them out to the neighbouring blocks.

Top module: `ser_regfile`

## Requirements
- R1: After reset, both queues are empty and disabled, the receiver is off, all interrupt lines are low, the state word reads 0, and the queue status word reads 0x1000_0000 (transmit free space 16 in bits 29:24).
- R2: The line-control word at 0x10, the pin select at 0x04, the baud reload at 0x50, the clock word at 0x00 (gate-off at bit 1, divider in bits 15:8) and the interrupt enables at 0xF4 (bits 3:0) read back exactly what was written, masked to their widths. Offset 0x08 returns the ID_VALUE parameter. The write-only registers at 0x18 and 0xF8 read as 0.
- R3: A write to 0x20 pushes bits 7:0 into the transmit queue when that queue is enabled and holds fewer than 16 entries. A write to a full queue is dropped. The engine pops bytes in write order, and tx_avail is high exactly while the queue is not empty.
- R4: A read of 0x24 returns the oldest received byte in bits 7:0 and removes it. A read of 0x24 while the receive queue is empty returns 0 and leaves the queue unchanged.
- R5: The status word at 0x48 holds the receive fill level in bits 5:0, the transmit fill level in bits 13:8 and the transmit free space (16 minus the fill level) in bits 29:24.
- R6: The queue controls live at 0x40 (receive) and 0x44 (transmit). Each has enable at bit 0, flush at bit 1 and trigger level in bits 13:8. Writing 1 to the flush bit empties that queue, and the flush bit always reads 0. A disabled queue accepts no new entries.
- R7: The state word at 0x14 shows the receiver enable at bit 0, the parity flag at bit 16, the framing flag at bit 17 and the overrun flag at bit 19. An accepted byte marked bad sets the matching flag. A byte that arrives while the receive queue is full is dropped and sets the overrun flag. The flags stay set until they are cleared.
- R8: At 0x18, writing 1 to bit 0 clears the receiver enable and writing 1 to bit 1 sets it (clear wins if both are 1). Writing 1 to bit 2, 3 or 5 clears the parity, framing or overrun flag respectively. A write to 0x14 changes nothing.
- R9: While the receiver enable is clear, bytes from the engine are discarded and set no flag.
- R10: The receive request becomes pending when the receive fill level is non-zero and at or above its trigger level. It stays pending until a 1 is written to bit 1 of 0xF8. irq_rx is the pending request gated by enable bit 1.
- R11: The transmit request becomes pending when the transmit fill level is at or below its trigger level. It is cleared by bit 0 of 0xF8 and gated by enable bit 0. Enable bit 3 additionally drives irq_tx high for as long as the transmit queue is empty.
- R12: The error request becomes pending when a byte sets any error flag, and stays pending until a 1 is written to bit 2 of 0xF8. An error event in the same cycle as the clear keeps it pending. irq_err is the pending request gated by enable bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read strobe |
| tx_pop | input | 1 | Engine takes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit queue |
| tx_avail | output | 1 | Transmit queue holds at least one byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Received byte had a parity error |
| rx_ferr | input | 1 | Received byte had a framing error |
| cfg_line | output | 32 | Line-control word for the engine |
| cfg_pin | output | PIN_W | Pin select |
| cfg_reload | output | BRL_W | Baud reload value |
| cfg_clk_off | output | 1 | Clock gate-off request |
| cfg_clk_div | output | 8 | Clock divider |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle. They also assume that the engine pulses tx_pop only while tx_avail is high and sets the error marks only together with rx_push. The bench drives each strobe for exactly one cycle through tasks that pulse one line and release it. Engine pops are made only after the bench has sampled tx_avail high. Random receive traffic deliberately overruns the queue so that the overrun path is exercised, while every bus access stays a single, non-overlapping strobe.

// File: rtl/ser_regs_pkg.sv
package ser_regs_pkg;

    localparam int ADDR_W = 8;

    // register byte offsets
    localparam logic [ADDR_W-1:0] A_CLK    = 8'h00;
    localparam logic [ADDR_W-1:0] A_PIN    = 8'h04;
    localparam logic [ADDR_W-1:0] A_ID     = 8'h08;
    localparam logic [ADDR_W-1:0] A_LINE   = 8'h10;
    localparam logic [ADDR_W-1:0] A_STATE  = 8'h14;
    localparam logic [ADDR_W-1:0] A_SETCLR = 8'h18;
    localparam logic [ADDR_W-1:0] A_TXBUF  = 8'h20;
    localparam logic [ADDR_W-1:0] A_RXBUF  = 8'h24;
    localparam logic [ADDR_W-1:0] A_RXCTL  = 8'h40;
    localparam logic [ADDR_W-1:0] A_TXCTL  = 8'h44;
    localparam logic [ADDR_W-1:0] A_QSTAT  = 8'h48;
    localparam logic [ADDR_W-1:0] A_RELOAD = 8'h50;
    localparam logic [ADDR_W-1:0] A_IEN    = 8'hF4;
    localparam logic [ADDR_W-1:0] A_ICLR   = 8'hF8;

    // bit positions
    localparam int B_PERR = 16;
    localparam int B_FERR = 17;
    localparam int B_OVR  = 19;
    localparam int LVL_W  = 6;

    typedef struct packed {
        logic             en;
        logic [LVL_W-1:0] trig;
    } qcfg_t;

    typedef struct packed {
        logic ovr;
        logic ferr;
        logic perr;
    } errs_t;

endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full  = (s_q.cnt == CW'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign count = s_q.cnt;
    assign dout  = mem[s_q.rp];

    always_comb begin
        s_d     = s_q;
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push)
                s_d.wp = (s_q.wp == AW'(DEPTH-1)) ? '0 : s_q.wp + 1'b1;
            if (do_pop)
                s_d.rp = (s_q.rp == AW'(DEPTH-1)) ? '0 : s_q.rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wp] <= din;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (s_q.cnt == $past(s_q.cnt)));

    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty);

    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/ser_irq_ctl.sv
module ser_irq_ctl #(
    parameter int CW = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CW-1:0]                 rx_cnt,
    input  logic [CW-1:0]                 tx_cnt,
    input  logic [ser_regs_pkg::LVL_W-1:0] rx_trig,
    input  logic [ser_regs_pkg::LVL_W-1:0] tx_trig,
    input  logic                          tx_empty,
    input  logic [3:0]                    ien,
    input  logic [2:0]                    clr,
    input  logic                          err_evt,
    output logic                          irq_tx,
    output logic                          irq_rx,
    output logic                          irq_err
);
    localparam int CMP_W = ((CW > ser_regs_pkg::LVL_W) ? CW : ser_regs_pkg::LVL_W) + 1;

    typedef struct packed {
        logic tx;
        logic rx;
        logic err;
    } pend_t;

    pend_t p_d, p_q;
    logic  rx_hit, tx_hit;

    always_comb begin
        rx_hit = (rx_cnt != '0) && (CMP_W'(rx_cnt) >= CMP_W'(rx_trig));
        tx_hit = CMP_W'(tx_cnt) <= CMP_W'(tx_trig);
        p_d     = p_q;
        p_d.rx  = clr[1] ? 1'b0 : (p_q.rx | rx_hit);
        p_d.tx  = clr[0] ? 1'b0 : (p_q.tx | tx_hit);
        p_d.err = (p_q.err & ~clr[2]) | err_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign irq_rx  = p_q.rx & ien[1];
    assign irq_tx  = (p_q.tx & ien[0]) | (tx_empty & ien[3]);
    assign irq_err = p_q.err & ien[2];

    p_rx_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.rx && !clr[1]) |=> p_q.rx);

    p_tx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr[0] |=> !p_q.tx);

    p_err_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> p_q.err);

endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
    import ser_regs_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter int          PIN_W    = 1,
    parameter int          BRL_W    = 13,
    parameter logic [31:0] ID_VALUE = 32'h0051_C0DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tx_pop,
    output logic [7:0]        tx_byte,
    output logic              tx_avail,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic [31:0]       cfg_line,
    output logic [PIN_W-1:0]  cfg_pin,
    output logic [BRL_W-1:0]  cfg_reload,
    output logic              cfg_clk_off,
    output logic [7:0]        cfg_clk_div,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [31:0]      line;
        logic [PIN_W-1:0] pin;
        logic [BRL_W-1:0] reload;
        logic             clk_off;
        logic [7:0]       clk_div;
        logic [3:0]       ien;
        qcfg_t            rxc;
        qcfg_t            txc;
        logic             ren;
        errs_t            err;
        logic [31:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [CW-1:0] rx_cnt, tx_cnt;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic [7:0]    rx_head;
    logic          rx_take, rx_pop_b, tx_push_b;
    logic          rx_flush, tx_flush;
    logic          sc_wr;
    logic [2:0]    iclr;
    errs_t         evt;
    logic [31:0]   state_w, qstat_w;

    // ---------------- side decodes ----------------
    assign rx_take   = rx_push && r_q.ren && r_q.rxc.en;
    assign rx_pop_b  = bus_rd && (bus_addr == A_RXBUF);
    assign tx_push_b = bus_wr && (bus_addr == A_TXBUF) && r_q.txc.en;
    assign rx_flush  = bus_wr && (bus_addr == A_RXCTL) && bus_wdata[1];
    assign tx_flush  = bus_wr && (bus_addr == A_TXCTL) && bus_wdata[1];
    assign sc_wr     = bus_wr && (bus_addr == A_SETCLR);
    assign iclr      = (bus_wr && (bus_addr == A_ICLR)) ? bus_wdata[2:0] : 3'b000;

    always_comb begin
        evt.perr = rx_take && rx_perr;
        evt.ferr = rx_take && rx_ferr;
        evt.ovr  = rx_take && rx_full;
    end

    always_comb begin
        state_w         = '0;
        state_w[0]      = r_q.ren;
        state_w[B_PERR] = r_q.err.perr;
        state_w[B_FERR] = r_q.err.ferr;
        state_w[B_OVR]  = r_q.err.ovr;
        qstat_w         = '0;
        qstat_w[5:0]    = LVL_W'(rx_cnt);
        qstat_w[13:8]   = LVL_W'(tx_cnt);
        qstat_w[29:24]  = LVL_W'(DEPTH) - LVL_W'(tx_cnt);
    end

    // ---------------- next-state ----------------
    always_comb begin
        r_d       = r_q;
        r_d.rdata = '0;

        if (bus_wr) begin
            case (bus_addr)
                A_CLK: begin
                    r_d.clk_off = bus_wdata[1];
                    r_d.clk_div = bus_wdata[15:8];
                end
                A_PIN:    r_d.pin    = bus_wdata[PIN_W-1:0];
                A_LINE:   r_d.line   = bus_wdata;
                A_RELOAD: r_d.reload = bus_wdata[BRL_W-1:0];
                A_IEN:    r_d.ien    = bus_wdata[3:0];
                A_RXCTL: begin
                    r_d.rxc.en   = bus_wdata[0];
                    r_d.rxc.trig = bus_wdata[13:8];
                end
                A_TXCTL: begin
                    r_d.txc.en   = bus_wdata[0];
                    r_d.txc.trig = bus_wdata[13:8];
                end
                default: ;
            endcase
        end

        if (sc_wr) begin
            if (bus_wdata[0])      r_d.ren = 1'b0;
            else if (bus_wdata[1]) r_d.ren = 1'b1;
        end

        // new error events win over a clear in the same cycle
        r_d.err.perr = (r_q.err.perr & ~(sc_wr & bus_wdata[2])) | evt.perr;
        r_d.err.ferr = (r_q.err.ferr & ~(sc_wr & bus_wdata[3])) | evt.ferr;
        r_d.err.ovr  = (r_q.err.ovr  & ~(sc_wr & bus_wdata[5])) | evt.ovr;

        if (bus_rd) begin
            case (bus_addr)
                A_CLK:    r_d.rdata = {16'b0, r_q.clk_div, 6'b0, r_q.clk_off, 1'b0};
                A_PIN:    r_d.rdata = 32'(r_q.pin);
                A_ID:     r_d.rdata = ID_VALUE;
                A_LINE:   r_d.rdata = r_q.line;
                A_STATE:  r_d.rdata = state_w;
                A_RXBUF:  r_d.rdata = rx_empty ? 32'b0 : {24'b0, rx_head};
                A_RXCTL:  r_d.rdata = {18'b0, r_q.rxc.trig, 7'b0, r_q.rxc.en};
                A_TXCTL:  r_d.rdata = {18'b0, r_q.txc.trig, 7'b0, r_q.txc.en};
                A_QSTAT:  r_d.rdata = qstat_w;
                A_RELOAD: r_d.rdata = 32'(r_q.reload);
                A_IEN:    r_d.rdata = {28'b0, r_q.ien};
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // ---------------- queues ----------------
    ser_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (rx_flush),
        .push  (rx_take),
        .din   (rx_byte),
        .pop   (rx_pop_b),
        .dout  (rx_head),
        .full  (rx_full),
        .empty (rx_empty),
        .count (rx_cnt)
    );

    ser_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (tx_flush),
        .push  (tx_push_b),
        .din   (bus_wdata[7:0]),
        .pop   (tx_pop),
        .dout  (tx_byte),
        .full  (tx_full),
        .empty (tx_empty),
        .count (tx_cnt)
    );

    ser_irq_ctl #(.CW(CW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_cnt   (rx_cnt),
        .tx_cnt   (tx_cnt),
        .rx_trig  (r_q.rxc.trig),
        .tx_trig  (r_q.txc.trig),
        .tx_empty (tx_empty),
        .ien      (r_q.ien),
        .clr      (iclr),
        .err_evt  (|evt),
        .irq_tx   (irq_tx),
        .irq_rx   (irq_rx),
        .irq_err  (irq_err)
    );

    assign tx_avail    = !tx_empty;
    assign bus_rdata   = r_q.rdata;
    assign cfg_line    = r_q.line;
    assign cfg_pin     = r_q.pin;
    assign cfg_reload  = r_q.reload;
    assign cfg_clk_off = r_q.clk_off;
    assign cfg_clk_div = r_q.clk_div;

    // ---------------- checks ----------------
    p_rxoff_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !r_q.ren) |=> (rx_cnt <= $past(rx_cnt)));

    p_overrun_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && r_q.ren && r_q.rxc.en && rx_full) |=> r_q.err.ovr);

    p_state_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_STATE) && !rx_push) |=> ($stable(r_q.err) && $stable(r_q.ren)));

    p_txfull_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push_b && !tx_pop) |=> tx_full);

endmodule

// File: tb/sim_ser_regfile.sv
module sim_ser_regfile;
    import ser_regs_pkg::*;

    localparam logic [31:0] IDV = 32'h0051_C0DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_perr = 1'b0, rx_ferr = 1'b0;
    logic [31:0] cfg_line;
    logic [0:0]  cfg_pin;
    logic [12:0] cfg_reload;
    logic        cfg_clk_off;
    logic [7:0]  cfg_clk_div;
    logic        irq_tx, irq_rx, irq_err;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ser_regfile #(.DEPTH(16), .PIN_W(1), .BRL_W(13), .ID_VALUE(IDV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .tx_avail(tx_avail), .rx_push(rx_push), .rx_byte(rx_byte), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .cfg_line(cfg_line), .cfg_pin(cfg_pin), .cfg_reload(cfg_reload),
        .cfg_clk_off(cfg_clk_off), .cfg_clk_div(cfg_clk_div),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic push(input logic [7:0] b, input logic pe, input logic fe);
        @(negedge clk);
        rx_byte = b; rx_perr = pe; rx_ferr = fe; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic pop(output logic ok, output logic [7:0] b);
        @(negedge clk);
        ok = tx_avail; b = tx_byte;
        if (ok) tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    function automatic logic [31:0] qstat(input int rxn, input int txn);
        return (32'(16 - txn) << 24) | (32'(txn) << 8) | 32'(rxn);
    endfunction

    function automatic logic [31:0] stat(input logic ren, input logic pe, input logic fe, input logic ov);
        return {12'b0, ov, 1'b0, fe, pe, 15'b0, ren};
    endfunction

    initial begin : wdog
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, v;
        logic [7:0]  b;
        logic        ok;
        logic [7:0]  txq[$];
        logic [7:0]  rxq[$];
        logic        m_pe, m_fe, m_ov;
        void'($urandom(32'h5EED));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq lines", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);
        rd(A_QSTAT, d); chk("R1 R5 status after reset", d, 32'h1000_0000);
        rd(A_STATE, d); chk("R1 state after reset", d, 32'h0);
        rd(A_ID, d);    chk("R2 id", d, IDV);

        // R2 read-back
        v = $urandom; wr(A_LINE, v);   rd(A_LINE, d);   chk("R2 line word", d, v);
        chk("R2 line out", cfg_line, v);
        v = $urandom; wr(A_RELOAD, v); rd(A_RELOAD, d); chk("R2 reload", d, v & 32'h1FFF);
        v = $urandom; wr(A_PIN, v);    rd(A_PIN, d);    chk("R2 pin", d, v & 32'h1);
        v = $urandom; wr(A_CLK, v);    rd(A_CLK, d);    chk("R2 clock word", d, v & 32'hFF02);
        v = $urandom; wr(A_IEN, v);    rd(A_IEN, d);    chk("R2 ien", d, v & 32'hF);
        wr(A_IEN, 32'h0);
        rd(A_SETCLR, d); chk("R2 setclr reads zero", d, 32'h0);
        rd(A_ICLR, d);   chk("R2 iclr reads zero", d, 32'h0);

        // R8 state not directly writable
        wr(A_STATE, 32'hFFFF_FFFF); rd(A_STATE, d); chk("R8 state write ignored", d, 32'h0);

        // R6 disabled tx queue accepts nothing
        wr(A_TXBUF, 32'h55); rd(A_QSTAT, d); chk("R6 disabled tx queue", d, qstat(0, 0));

        // R3 random tx fill beyond depth
        wr(A_TXCTL, 32'h1);
        for (int i = 0; i < 20; i++) begin
            v = $urandom;
            wr(A_TXBUF, v);
            if (txq.size() < 16) txq.push_back(v[7:0]);
        end
        rd(A_QSTAT, d); chk("R5 tx full status", d, qstat(0, 16));
        for (int i = 0; i < 16; i++) begin
            pop(ok, b);
            chk("R3 tx avail", {31'b0, ok}, 32'h1);
            chk("R3 tx order", {24'b0, b}, {24'b0, txq.pop_front()});
        end
        @(negedge clk);
        chk("R3 tx avail low when empty", {31'b0, tx_avail}, 32'h0);

        // R9 receiver disabled
        wr(A_RXCTL, 32'h1);
        push(8'hA1, 1'b1, 1'b1);
        rd(A_QSTAT, d); chk("R9 rx discarded", d, qstat(0, 0));
        rd(A_STATE, d); chk("R9 no flags", d, 32'h0);

        // R8 set receiver enable; R4 empty read
        wr(A_SETCLR, 32'h2);
        rd(A_STATE, d); chk("R8 ren set", d, stat(1, 0, 0, 0));
        rd(A_RXBUF, d); chk("R4 empty read zero", d, 32'h0);
        rd(A_QSTAT, d); chk("R4 empty read keeps level", d, qstat(0, 0));

        // R4 R7 random receive traffic
        m_pe = 0; m_fe = 0; m_ov = 0;
        for (int i = 0; i < 60; i++) begin
            if ($urandom % 3 != 0) begin
                logic pe, fe;
                b = 8'($urandom); pe = ($urandom % 8 == 0); fe = ($urandom % 8 == 0);
                push(b, pe, fe);
                if (rxq.size() < 16) rxq.push_back(b); else m_ov = 1;
                m_pe |= pe; m_fe |= fe;
            end else begin
                rd(A_RXBUF, d);
                chk("R4 rx data", d, (rxq.size() != 0) ? {24'b0, rxq.pop_front()} : 32'h0);
            end
        end
        rd(A_STATE, d); chk("R7 random flags", d, stat(1, m_pe, m_fe, m_ov));
        rd(A_QSTAT, d); chk("R5 rx level", d, qstat(rxq.size(), 0));

        // R6 flush and clear flags
        wr(A_RXCTL, 32'h3); rxq.delete();
        rd(A_QSTAT, d); chk("R6 rx flush", d, qstat(0, 0));
        rd(A_RXCTL, d); chk("R6 flush self-clears", d, 32'h1);
        wr(A_SETCLR, 32'h2C);
        rd(A_STATE, d); chk("R8 all flags cleared", d, stat(1, 0, 0, 0));

        // R7 directed: parity then overrun
        push(8'h11, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) push(8'(i), 1'b0, 1'b0);
        rd(A_STATE, d); chk("R7 parity and overrun", d, stat(1, 1, 0, 1));
        rd(A_RXBUF, d); chk("R7 first byte kept", d, 32'h11);
        wr(A_SETCLR, 32'h4);
        rd(A_STATE, d); chk("R8 clear parity only", d, stat(1, 0, 0, 1));
        wr(A_SETCLR, 32'h20);
        rd(A_STATE, d); chk("R8 clear overrun", d, stat(1, 0, 0, 0));
        wr(A_RXCTL, 32'h3);

        // R10 receive interrupt
        wr(A_ICLR, 32'h7);
        wr(A_IEN, 32'h2);
        wr(A_RXCTL, 32'h0301);
        push(8'h01, 0, 0); push(8'h02, 0, 0);
        repeat (2) @(negedge clk);
        chk("R10 below trigger", {31'b0, irq_rx}, 32'h0);
        push(8'h03, 0, 0);
        repeat (2) @(negedge clk);
        chk("R10 at trigger", {31'b0, irq_rx}, 32'h1);
        rd(A_RXBUF, d);
        repeat (2) @(negedge clk);
        chk("R10 sticky after drain", {31'b0, irq_rx}, 32'h1);
        wr(A_ICLR, 32'h2);
        repeat (2) @(negedge clk);
        chk("R10 cleared", {31'b0, irq_rx}, 32'h0);

        // R11 transmit interrupt
        wr(A_IEN, 32'h1);
        wr(A_TXCTL, 32'h0201);
        repeat (2) @(negedge clk);
        chk("R11 pending when low", {31'b0, irq_tx}, 32'h1);
        for (int i = 0; i < 4; i++) wr(A_TXBUF, 32'(i));
        wr(A_ICLR, 32'h1);
        repeat (2) @(negedge clk);
        chk("R11 cleared above trigger", {31'b0, irq_tx}, 32'h0);
        pop(ok, b); pop(ok, b);
        repeat (2) @(negedge clk);
        chk("R11 at trigger", {31'b0, irq_tx}, 32'h1);
        pop(ok, b); pop(ok, b);
        wr(A_IEN, 32'h8);
        @(negedge clk);
        chk("R11 empty enable", {31'b0, irq_tx}, 32'h1);
        wr(A_TXBUF, 32'h9);
        @(negedge clk);
        chk("R11 not empty", {31'b0, irq_tx}, 32'h0);
        pop(ok, b);

        // R12 error interrupt
        wr(A_IEN, 32'h4);
        wr(A_ICLR, 32'h4);
        @(negedge clk);
        chk("R12 cleared", {31'b0, irq_err}, 32'h0);
        push(8'h77, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R12 framing raises", {31'b0, irq_err}, 32'h1);
        wr(A_ICLR, 32'h4);
        @(negedge clk);
        chk("R12 clear", {31'b0, irq_err}, 32'h0);

        // R8 receiver off
        wr(A_SETCLR, 32'h3);
        rd(A_STATE, d); chk("R8 clear wins for ren", d & 32'h1, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule